// File: doc/BRIEF.md
# Packed Lane Integer ALU

This block is a one-stage arithmetic unit for packed integer data. A 64-bit word is split into equal lanes of 8, 16, 32 or 64 bits. Each operation runs on every lane in parallel, and no carry, borrow or shifted bit passes from one lane into another. The operations are add and subtract, each with a wrapping form and an unsigned saturating form. There is also an equality compare that produces a lane mask, a logical right shift per lane, and whole-word AND, OR and XOR.

An issuing stage presents two operands, an opcode, a lane-size code and a shift count, and raises `in_valid`. The block captures the result in an output register. On the next clock edge it shows the result together with `out_valid`. The word width, the narrowest lane and the number of lane sizes are parameters. The defaults give the 8/16/32/64-bit arrangement.

Top module: `simd_alu`

## Requirements
- R1: `lane_sz` selects the lane width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. With opcode 0, each lane holds the sum of its operand lanes modulo 2^width, and no carry crosses a lane boundary.
- R2: Opcode 2 puts the difference a-b modulo 2^width in each lane, and no borrow crosses a lane boundary.
- R3: Opcode 1 is an unsigned saturating add. A lane whose true sum exceeds the lane maximum gives all ones; any other lane gives the plain sum.
- R4: Opcode 3 is an unsigned saturating subtract. A lane where b exceeds a gives zero; any other lane gives a-b.
- R5: Opcode 4 sets every bit of a lane to one when the two operand lanes are equal, and clears every bit of the lane otherwise.
- R6: Opcodes 5, 6 and 7 give the bitwise AND, OR and XOR of the whole words. The result does not depend on `lane_sz`.
- R7: Opcode 8 shifts each lane of `src_a` right by `shamt` and fills with zeros. When `shamt` is equal to or greater than the lane width, the lane becomes zero.
- R8: Opcodes 9 to 15 give an all-zero result.
- R9: `out_valid` is high in the cycle after an accepted `in_valid`, and low in the cycle after a cycle in which `in_valid` is low. While `in_valid` is low, `result` keeps its last value.
- R10: While reset (`rst_n` low) is applied and after it is released, `result` reads zero and `out_valid` reads low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op | input | 4 | Operation code |
| lane_sz | input | 2 | Lane width code |
| shamt | input | 7 | Shift count for opcode 8 |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Registered result |

## Verification
The bench applies directed words that cover each lane boundary in turn. One case carries 0xFF plus 1 across a byte edge. Another borrows from a zero lane next to a non-zero lane. Others saturate exactly one lane among several, and shift by exactly the lane width and by one bit less. Together these show whether lanes are cut at the selected width and not at some other width. Random operands come next. They are biased toward all-ones and all-zero lanes, and toward pairs with equal lanes, so that the saturating and compare paths both take each branch. Unused opcodes and idle cycles with changing inputs then show that nothing leaks to the output outside the stated operations.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_ADDS  = 4'd1,
      OP_SUB   = 4'd2,
      OP_SUBS  = 4'd3,
      OP_CMPEQ = 4'd4,
      OP_AND   = 4'd5,
      OP_OR    = 4'd6,
      OP_XOR   = 4'd7,
      OP_SRL   = 4'd8
   } simd_op_e;

   localparam int OP_W = 4;

endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
   import simd_alu_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int SH_W   = 7
) (
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   input  logic [OP_W-1:0]   op,
   input  logic [SH_W-1:0]   shamt,
   output logic [LANE_W-1:0] y
);

   localparam int EXT_W = LANE_W + 1;
   localparam logic [SH_W:0] SH_LIMIT = (SH_W + 1)'(LANE_W);

   logic [EXT_W-1:0] sum_ext;
   logic [EXT_W-1:0] dif_ext;
   logic             shift_out;

   assign sum_ext   = {1'b0, a} + {1'b0, b};
   assign dif_ext   = {1'b0, a} - {1'b0, b};
   assign shift_out = ({1'b0, shamt} >= SH_LIMIT);

   always_comb begin
      case (op)
         OP_ADD:   y = sum_ext[LANE_W-1:0];
         OP_ADDS:  y = sum_ext[LANE_W] ? {LANE_W{1'b1}} : sum_ext[LANE_W-1:0];
         OP_SUB:   y = dif_ext[LANE_W-1:0];
         OP_SUBS:  y = dif_ext[LANE_W] ? {LANE_W{1'b0}} : dif_ext[LANE_W-1:0];
         OP_CMPEQ: y = (a == b) ? {LANE_W{1'b1}} : {LANE_W{1'b0}};
         OP_AND:   y = a & b;
         OP_OR:    y = a | b;
         OP_XOR:   y = a ^ b;
         OP_SRL:   y = shift_out ? {LANE_W{1'b0}} : (a >> shamt);
         default:  y = {LANE_W{1'b0}};
      endcase
   end

endmodule

// File: rtl/simd_lane_group.sv
module simd_lane_group
   import simd_alu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8,
   parameter int SH_W   = 7
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [OP_W-1:0]   op,
   input  logic [SH_W-1:0]   shamt,
   output logic [DATA_W-1:0] y
);

   localparam int NUM_LANES = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0) begin : g_bad_split
      $error("simd_lane_group: DATA_W must be a multiple of LANE_W");
   end

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      simd_lane_unit #(
         .LANE_W (LANE_W),
         .SH_W   (SH_W)
      ) u_lane (
         .a     (a[i*LANE_W +: LANE_W]),
         .b     (b[i*LANE_W +: LANE_W]),
         .op    (op),
         .shamt (shamt),
         .y     (y[i*LANE_W +: LANE_W])
      );
   end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
   import simd_alu_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int MIN_LANE_W = 8,
   parameter int NUM_SIZES  = 4,
   localparam int LSZ_W     = (NUM_SIZES > 1) ? $clog2(NUM_SIZES) : 1,
   localparam int SH_W      = $clog2(DATA_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   op,
   input  logic [LSZ_W-1:0]  lane_sz,
   input  logic [SH_W-1:0]   shamt,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);

   localparam int MAX_LANE_W = MIN_LANE_W << (NUM_SIZES - 1);

   if (NUM_SIZES != (1 << LSZ_W)) begin : g_bad_sizes
      $error("simd_alu: NUM_SIZES must be a power of two");
   end
   if (MAX_LANE_W > DATA_W || DATA_W % MAX_LANE_W != 0) begin : g_bad_width
      $error("simd_alu: widest lane must divide DATA_W");
   end

   logic [DATA_W-1:0] by_size [NUM_SIZES];
   logic [DATA_W-1:0] next_res;

   for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
      simd_lane_group #(
         .DATA_W (DATA_W),
         .LANE_W (MIN_LANE_W << k),
         .SH_W   (SH_W)
      ) u_group (
         .a     (src_a),
         .b     (src_b),
         .op    (op),
         .shamt (shamt),
         .y     (by_size[k])
      );
   end

   assign next_res = by_size[lane_sz];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= next_res;
         end
      end
   end

   // ---------------- assertions ----------------
   assert_valid_lat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(in_valid)));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   assert_xor_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_XOR) |=> ((result ^ $past(src_b)) == $past(src_a)));

   assert_and_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_AND) |=> ((result & ~$past(src_a)) == '0));

   assert_srl_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_SRL && shamt >= SH_W'(DATA_W)) |=> (result == '0));

   assert_unused_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op > OP_SRL) |=> (result == '0));

   assert_satadd_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_ADDS && lane_sz == LSZ_W'(NUM_SIZES - 1) && DATA_W == MAX_LANE_W)
      |=> (result >= $past(src_a) && result >= $past(src_b)));

   for (genvar j = 0; j < DATA_W / MIN_LANE_W; j++) begin : g_mask_chk
      assert_cmp_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op == OP_CMPEQ && lane_sz == '0)
         |=> (result[j*MIN_LANE_W +: MIN_LANE_W] == '0 ||
              result[j*MIN_LANE_W +: MIN_LANE_W] == '1));
   end

endmodule

// File: tb/simd_alu_test.sv
module simd_alu_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  op = '0;
   logic [1:0]  lane_sz = '0;
   logic [6:0]  shamt = '0;
   logic [63:0] src_a = '0;
   logic [63:0] src_b = '0;
   logic        out_valid;
   logic [63:0] result;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   simd_alu uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .lane_sz(lane_sz), .shamt(shamt), .src_a(src_a), .src_b(src_b),
      .out_valid(out_valid), .result(result)
   );

   function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                         logic [3:0] o, logic [1:0] sz, logic [6:0] sh);
      int L = 8 << sz;
      int n = 64 / L;
      logic [64:0] m, ea, eb, r;
      logic [63:0] acc;
      acc = '0;
      m = (65'd1 << L) - 65'd1;
      for (int i = 0; i < n; i++) begin
         ea = ({1'b0, a} >> (i * L)) & m;
         eb = ({1'b0, b} >> (i * L)) & m;
         case (o)
            4'd0: r = (ea + eb) & m;
            4'd1: r = ((ea + eb) > m) ? m : (ea + eb);
            4'd2: r = (ea - eb) & m;
            4'd3: r = (ea < eb) ? 65'd0 : (ea - eb);
            4'd4: r = (ea == eb) ? m : 65'd0;
            4'd5: r = ea & eb;
            4'd6: r = ea | eb;
            4'd7: r = ea ^ eb;
            4'd8: r = (int'(sh) >= L) ? 65'd0 : (ea >> sh);
            default: r = 65'd0;
         endcase
         acc = acc | 64'(r << (i * L));
      end
      return acc;
   endfunction

   function automatic string tag_of(logic [3:0] o);
      case (o)
         4'd0: return "R1";
         4'd1: return "R3";
         4'd2: return "R2";
         4'd3: return "R4";
         4'd4: return "R5";
         4'd5, 4'd6, 4'd7: return "R6";
         4'd8: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(string req, logic [63:0] got, logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // drive at negedge, sample at the following negedge (one register stage)
   task automatic apply(logic [63:0] a, logic [63:0] b, logic [3:0] o,
                        logic [1:0] sz, logic [6:0] sh);
      src_a = a; src_b = b; op = o; lane_sz = sz; shamt = sh; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(tag_of(o), result, model(a, b, o, sz, sh));
      check("R9", {63'd0, out_valid}, 64'd1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin : stim
      logic [63:0] held;
      repeat (3) @(negedge clk);
      check("R10", result, 64'd0);
      check("R10", {63'd0, out_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", result, 64'd0);
      check("R10", {63'd0, out_valid}, 64'd0);

      // R1: carry stops at the byte edge; same word at 16-bit lanes carries
      apply(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 4'd0, 2'd0, 7'd0);
      check("R1", result, 64'h0000_0000_0000_0000);
      apply(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 4'd0, 2'd1, 7'd0);
      check("R1", result, 64'h0100_0100_0100_0100);
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 4'd0, 2'd3, 7'd0);
      // R2: borrow does not cross a lane boundary
      apply(64'h0100_0100_0100_0100, 64'h0001_0001_0001_0001, 4'd2, 2'd0, 7'd0);
      check("R2", result, 64'h01FF_01FF_01FF_01FF);
      apply(64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 4'd2, 2'd2, 7'd0);
      // R3: one lane saturates, the others add plainly
      apply(64'h10FF_2000_3000_4000, 64'h0102_0100_0100_0100, 4'd1, 2'd0, 7'd0);
      check("R3", result, 64'h11FF_2100_3100_4100);
      apply(64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 4'd1, 2'd3, 7'd0);
      check("R3", result, 64'hFFFF_FFFF_FFFF_FFFF);
      // R4: negative lane clamps to zero
      apply(64'h0005_0010_0000_8000, 64'h0006_0001_0001_8000, 4'd3, 2'd1, 7'd0);
      check("R4", result, 64'h0000_000F_0000_0000);
      // R5: mask per lane
      apply(64'h1122_3344_5566_7788, 64'h1122_3345_5566_0088, 4'd4, 2'd1, 7'd0);
      check("R5", result, 64'hFFFF_0000_FFFF_0000);
      // R6: logic ops ignore lane size
      apply(64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_AAAA, 4'd5, 2'd0, 7'd0);
      apply(64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_AAAA, 4'd6, 2'd3, 7'd0);
      apply(64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_AAAA, 4'd7, 2'd1, 7'd0);
      // R7: shift at width-1, width, and beyond
      apply(64'h8000_8000_8000_8000, 64'h0, 4'd8, 2'd1, 7'd15);
      check("R7", result, 64'h0001_0001_0001_0001);
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'd8, 2'd1, 7'd16);
      check("R7", result, 64'h0);
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'd8, 2'd3, 7'd64);
      check("R7", result, 64'h0);
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'd8, 2'd2, 7'd4);
      check("R7", result, 64'h0FFF_FFFF_0FFF_FFFF);
      // R8: unused opcodes
      for (int o = 9; o < 16; o++) begin
         apply(64'hDEAD_BEEF_CAFE_F00D, 64'h1234_5678_9ABC_DEF0, 4'(o), 2'(o), 7'd3);
      end

      // R9: idle cycles keep the result and drop out_valid
      held = result;
      in_valid = 1'b0;
      src_a = 64'h5555_AAAA_5555_AAAA; op = 4'd7;
      @(posedge clk);
      @(negedge clk);
      check("R9", {63'd0, out_valid}, 64'd0);
      check("R9", result, held);
      src_b = 64'hFFFF_0000_1111_2222; op = 4'd0;
      @(posedge clk);
      @(negedge clk);
      check("R9", result, held);

      // random mix with biased lanes
      void'($urandom(32'd1234));
      for (int t = 0; t < 3000; t++) begin
         logic [63:0] ra, rb;
         logic [3:0]  ro;
         ra = {$urandom, $urandom};
         rb = {$urandom, $urandom};
         case ($urandom_range(0, 3))
            0: rb = ra ^ (64'hFF << (8 * $urandom_range(0, 7)));
            1: ra = ra | 64'hFF00_FF00_FF00_FF00;
            2: rb = ra;
            default: ;
         endcase
         ro = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(9, 15))
                                          : 4'($urandom_range(0, 8));
         apply(ra, rb, ro, 2'($urandom_range(0, 3)), 7'($urandom_range(0, 70)));
      end

      in_valid = 1'b0;
      @(negedge clk);
      finish_run();
   end

endmodule